// File: doc/BRIEF.md
# Multicore Power Mode Sequencer

This block controls the power state of a group of processor cores. Each core has two switchable power domains: a logic domain that holds the pipeline, and a local-RAM domain that can stay powered on its own. A per-core request port selects one of five target modes: run, light-sleep, sleep, resume-standby and power-off. The block drives clock enables, power-switch enables, isolation, core reset and save/restore handshakes to reach that mode, and it reports each core's current mode as a 3-bit code.

Light-sleep gates the execution clock and keeps the snoop clock running, so caches stay coherent. Sleep gates both clocks while both domains stay powered. Resume-standby saves core state into the local RAM, isolates the logic domain and then removes its power; the RAM domain stays powered. Leaving resume-standby is the same steps in reverse: logic power first, then isolation release, then a restore from RAM. Power-off removes both domains, and leaving it is a cold restart with no restore. Every power-switch step waits for that domain's power-good acknowledge. A wait longer than a programmable limit raises a sticky error flag for that core.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset every core reports mode code 0 (run), with both clock enables high, both power enables high, isolation low, core reset released and the error flag low.
- R2: A request with code 1 (light-sleep) from run drops the execution clock enable and keeps the snoop clock enable and both power enables high; the mode code becomes 1.
- R3: A request with code 2 (sleep) drops both clock enables and keeps both power enables high; the mode code becomes 2.
- R4: A request with code 3 (resume-standby) from run first raises the save request and holds it until save-done. It then raises isolation, and only on a later cycle drops the logic power enable. The RAM power enable stays high. The mode code reads 5 (transitioning) during the sequence and 3 once the logic power-good goes low. A request for code 3 from light-sleep or sleep first passes through run (code 0).
- R5: Leaving resume-standby raises the logic power enable and waits for its power-good. Isolation falls on a strictly later cycle, together with a restore request that is held until restore-done. The core then reports 0, or continues to the pending mode.
- R6: A request with code 4 (power-off) drops the logic power enable before the RAM power enable, and reports 4 once both power-goods are low. From resume-standby it drops only the RAM domain. Leaving power-off powers RAM, then logic, and returns to run without any restore request. The RAM power enable is never low while the logic power enable is high.
- R7: Isolation of the logic domain is high on the cycle before its power enable falls, and stays high whenever that enable is low. Isolation falls only after a cycle in which the logic power-good was high.
- R8: Requests that arrive while a core reports 5 are held, the latest one winning, and are acted on only once the core reaches a stable mode. Request codes 5 to 7 are ignored.
- R9: While a core waits for a power-good, a counter runs. If the wait goes past `timeoutLimit` cycles, the core's error flag is set. The flag stays set until reset, and the sequence keeps waiting.
- R10: Each core's mode, clocks, power and error flag respond only to that core's own request and acknowledge inputs.
- R11: Core reset is held low, and both clock enables are low, whenever the logic power enable is low. Reset is released only once the power-up sequence is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeoutLimit | input | TIMEOUT_W | Maximum power-good wait, in cycles |
| reqValid | input | NUM_CORES | Per-core request strobe |
| reqMode | input | 3*NUM_CORES | Per-core requested mode code, core i at bits 3i+2:3i |
| cpuPwrGood | input | NUM_CORES | Logic-domain power-good acknowledge |
| ramPwrGood | input | NUM_CORES | RAM-domain power-good acknowledge |
| saveDone | input | NUM_CORES | Context save finished |
| restoreDone | input | NUM_CORES | Context restore finished |
| coreMode | output | 3*NUM_CORES | Per-core mode code (0 run, 1 light, 2 sleep, 3 standby, 4 off, 5 transitioning) |
| cpuClkEn | output | NUM_CORES | Execution clock enable |
| snoopClkEn | output | NUM_CORES | Snoop clock enable |
| cpuPwrEn | output | NUM_CORES | Logic-domain power switch enable |
| ramPwrEn | output | NUM_CORES | RAM-domain power switch enable |
| cpuIso | output | NUM_CORES | Logic-domain output isolation |
| coreRstN | output | NUM_CORES | Active-low core reset |
| saveReq | output | NUM_CORES | Context save request |
| restoreReq | output | NUM_CORES | Context restore request |
| errFlag | output | NUM_CORES | Sticky power-good timeout flag |

## Verification
The assertions take for granted that a power-good acknowledge only follows its own enable, after some delay. They also take for granted that save-done and restore-done are high only while the matching request is high. Under those conditions the handshakes close cleanly and the ordering checks hold. The bench models each power switch as a short flop chain behind its enable. The one exception is a freeze control that holds the last power-good value, which is used to stretch transitions and to provoke timeouts. The done signals are formed as the request ANDed with its own delayed copy, so the bench never drives an acknowledge the design did not ask for.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN   = 3'd0,
    MODE_LIGHT = 3'd1,
    MODE_SLEEP = 3'd2,
    MODE_RSTBY = 3'd3,
    MODE_OFF   = 3'd4,
    MODE_TRANS = 3'd5
  } coreMode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadActive;  // capture pending target as the active one
    logic waitAck;     // sequencer is waiting for a power-good edge
  } seqStrobe_t;

  localparam logic [MODE_W-1:0] MAX_REQ_CODE = 3'd4;

endpackage

// File: rtl/pwr_core_dp.sv
module pwr_core_dp
  import pwr_mode_pkg::*;
#(
  parameter int TIMEOUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [MODE_W-1:0]    reqMode,
  input  logic [TIMEOUT_W-1:0] timeoutLimit,
  input  seqStrobe_t           strb,
  output coreMode_e            pendMode,
  output coreMode_e            activeMode,
  output logic                 errFlag
);

  logic [TIMEOUT_W-1:0] waitCnt;
  logic                 reqOk;

  assign reqOk = reqValid && (reqMode <= MAX_REQ_CODE);

  // Latest legal request wins; applied by control when stable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode <= MODE_RUN;
    end else if (reqOk) begin
      pendMode <= coreMode_e'(reqMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode <= MODE_RUN;
    end else if (strb.loadActive) begin
      activeMode <= pendMode;
    end
  end

  // Power-good wait counter, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (!strb.waitAck) begin
      waitCnt <= '0;
    end else if (waitCnt < timeoutLimit) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strb.waitAck && (waitCnt >= timeoutLimit)) begin
      errFlag <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag); // R9

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode > MAX_REQ_CODE)) |=> $stable(pendMode)); // R8

endmodule

// File: rtl/pwr_core_ctrl.sv
module pwr_core_ctrl
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  coreMode_e  pendMode,
  input  coreMode_e  activeMode,
  input  logic       cpuPwrGood,
  input  logic       ramPwrGood,
  input  logic       saveDone,
  input  logic       restoreDone,
  output seqStrobe_t strb,
  output coreMode_e  coreMode,
  output logic       cpuClkEn,
  output logic       snoopClkEn,
  output logic       cpuPwrEn,
  output logic       ramPwrEn,
  output logic       cpuIso,
  output logic       coreRstN,
  output logic       saveReq,
  output logic       restoreReq
);

  typedef enum logic [3:0] {
    S_RUN, S_LIGHT, S_SLEEP, S_RSTBY, S_OFF,
    S_SAVE, S_ISO_ON, S_CPU_DOWN, S_RAM_DOWN,
    S_RAM_UP, S_CPU_UP_WARM, S_CPU_UP_COLD, S_RESTORE
  } seqState_e;

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_RUN;
    end else begin
      state <= stateNxt;
    end
  end

  // Next state and strobes
  always_comb begin
    stateNxt        = state;
    strb.loadActive = 1'b0;
    strb.waitAck    = 1'b0;
    unique case (state)
      S_RUN: begin
        unique case (pendMode)
          MODE_LIGHT: stateNxt = S_LIGHT;
          MODE_SLEEP: stateNxt = S_SLEEP;
          MODE_RSTBY: begin
            stateNxt        = S_SAVE;
            strb.loadActive = 1'b1;
          end
          MODE_OFF: begin
            stateNxt        = S_ISO_ON;
            strb.loadActive = 1'b1;
          end
          default: stateNxt = S_RUN;
        endcase
      end
      S_LIGHT, S_SLEEP: begin
        unique case (pendMode)
          MODE_LIGHT: stateNxt = S_LIGHT;
          MODE_SLEEP: stateNxt = S_SLEEP;
          default:    stateNxt = S_RUN;   // deeper modes go through run
        endcase
      end
      S_SAVE: begin
        if (saveDone) stateNxt = S_ISO_ON;
      end
      S_ISO_ON: stateNxt = S_CPU_DOWN;
      S_CPU_DOWN: begin
        strb.waitAck = 1'b1;
        if (!cpuPwrGood) begin
          stateNxt = (activeMode == MODE_OFF) ? S_RAM_DOWN : S_RSTBY;
        end
      end
      S_RAM_DOWN: begin
        strb.waitAck = 1'b1;
        if (!ramPwrGood) stateNxt = S_OFF;
      end
      S_RSTBY: begin
        if (pendMode == MODE_OFF) begin
          stateNxt        = S_RAM_DOWN;
          strb.loadActive = 1'b1;
        end else if (pendMode != MODE_RSTBY) begin
          stateNxt        = S_CPU_UP_WARM;
          strb.loadActive = 1'b1;
        end
      end
      S_OFF: begin
        if (pendMode != MODE_OFF) begin
          stateNxt        = S_RAM_UP;
          strb.loadActive = 1'b1;
        end
      end
      S_RAM_UP: begin
        strb.waitAck = 1'b1;
        if (ramPwrGood) stateNxt = S_CPU_UP_COLD;
      end
      S_CPU_UP_WARM: begin
        strb.waitAck = 1'b1;
        if (cpuPwrGood) stateNxt = S_RESTORE;
      end
      S_CPU_UP_COLD: begin
        strb.waitAck = 1'b1;
        if (cpuPwrGood) stateNxt = S_RUN;
      end
      S_RESTORE: begin
        if (restoreDone) stateNxt = S_RUN;
      end
      default: stateNxt = S_RUN;
    endcase
  end

  // Output decode per state
  always_comb begin
    cpuClkEn   = 1'b0;
    snoopClkEn = 1'b0;
    cpuPwrEn   = 1'b1;
    ramPwrEn   = 1'b1;
    cpuIso     = 1'b0;
    coreRstN   = 1'b1;
    saveReq    = 1'b0;
    restoreReq = 1'b0;
    coreMode   = MODE_TRANS;
    unique case (state)
      S_RUN: begin
        cpuClkEn   = 1'b1;
        snoopClkEn = 1'b1;
        coreMode   = MODE_RUN;
      end
      S_LIGHT: begin
        snoopClkEn = 1'b1;
        coreMode   = MODE_LIGHT;
      end
      S_SLEEP: coreMode = MODE_SLEEP;
      S_SAVE: begin
        cpuClkEn   = 1'b1;
        snoopClkEn = 1'b1;
        saveReq    = 1'b1;
      end
      S_ISO_ON: cpuIso = 1'b1;
      S_CPU_DOWN: begin
        cpuIso   = 1'b1;
        cpuPwrEn = 1'b0;
        coreRstN = 1'b0;
      end
      S_RAM_DOWN: begin
        cpuIso   = 1'b1;
        cpuPwrEn = 1'b0;
        ramPwrEn = 1'b0;
        coreRstN = 1'b0;
      end
      S_RSTBY: begin
        cpuIso   = 1'b1;
        cpuPwrEn = 1'b0;
        coreRstN = 1'b0;
        coreMode = MODE_RSTBY;
      end
      S_OFF: begin
        cpuIso   = 1'b1;
        cpuPwrEn = 1'b0;
        ramPwrEn = 1'b0;
        coreRstN = 1'b0;
        coreMode = MODE_OFF;
      end
      S_RAM_UP: begin
        cpuIso   = 1'b1;
        cpuPwrEn = 1'b0;
        coreRstN = 1'b0;
      end
      S_CPU_UP_WARM, S_CPU_UP_COLD: begin
        cpuIso   = 1'b1;
        coreRstN = 1'b0;
      end
      S_RESTORE: begin
        cpuClkEn   = 1'b1;
        snoopClkEn = 1'b1;
        restoreReq = 1'b1;
      end
      default: coreMode = MODE_TRANS;
    endcase
  end

  AST_ISO_BEFORE_CUT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuPwrEn) |-> $past(cpuIso)); // R7

  AST_ISO_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuIso) |-> $past(cpuPwrGood)); // R7

  AST_SAVE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(saveReq) |-> $past(saveDone)); // R4

  AST_RESTORE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(restoreReq) |-> $past(restoreDone)); // R5

  AST_RAM_AFTER_CPU: assert property (@(posedge clk) disable iff (!rstN)
    !ramPwrEn |-> !cpuPwrEn); // R6

  AST_GATED_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    !cpuPwrEn |-> (!cpuClkEn && !snoopClkEn && !coreRstN)); // R11

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((coreMode == MODE_TRANS) && ($past(coreMode) == MODE_TRANS))
      |-> $stable(activeMode)); // R8

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int TIMEOUT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [TIMEOUT_W-1:0]        timeoutLimit,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [NUM_CORES*MODE_W-1:0] reqMode,
  input  logic [NUM_CORES-1:0]        cpuPwrGood,
  input  logic [NUM_CORES-1:0]        ramPwrGood,
  input  logic [NUM_CORES-1:0]        saveDone,
  input  logic [NUM_CORES-1:0]        restoreDone,
  output logic [NUM_CORES*MODE_W-1:0] coreMode,
  output logic [NUM_CORES-1:0]        cpuClkEn,
  output logic [NUM_CORES-1:0]        snoopClkEn,
  output logic [NUM_CORES-1:0]        cpuPwrEn,
  output logic [NUM_CORES-1:0]        ramPwrEn,
  output logic [NUM_CORES-1:0]        cpuIso,
  output logic [NUM_CORES-1:0]        coreRstN,
  output logic [NUM_CORES-1:0]        saveReq,
  output logic [NUM_CORES-1:0]        restoreReq,
  output logic [NUM_CORES-1:0]        errFlag
);

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    seqStrobe_t strb;
    coreMode_e  pendMode;
    coreMode_e  activeMode;
    coreMode_e  modeOut;

    pwr_core_dp #(
      .TIMEOUT_W (TIMEOUT_W)
    ) u_dp (
      .clk          (clk),
      .rstN         (rstN),
      .reqValid     (reqValid[gi]),
      .reqMode      (reqMode[gi*MODE_W +: MODE_W]),
      .timeoutLimit (timeoutLimit),
      .strb         (strb),
      .pendMode     (pendMode),
      .activeMode   (activeMode),
      .errFlag      (errFlag[gi])
    );

    pwr_core_ctrl u_ctrl (
      .clk         (clk),
      .rstN        (rstN),
      .pendMode    (pendMode),
      .activeMode  (activeMode),
      .cpuPwrGood  (cpuPwrGood[gi]),
      .ramPwrGood  (ramPwrGood[gi]),
      .saveDone    (saveDone[gi]),
      .restoreDone (restoreDone[gi]),
      .strb        (strb),
      .coreMode    (modeOut),
      .cpuClkEn    (cpuClkEn[gi]),
      .snoopClkEn  (snoopClkEn[gi]),
      .cpuPwrEn    (cpuPwrEn[gi]),
      .ramPwrEn    (ramPwrEn[gi]),
      .cpuIso      (cpuIso[gi]),
      .coreRstN    (coreRstN[gi]),
      .saveReq     (saveReq[gi]),
      .restoreReq  (restoreReq[gi])
    );

    assign coreMode[gi*MODE_W +: MODE_W] = modeOut;
  end

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  localparam int N  = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] timeoutLimit = 16'd1000;
  logic [N-1:0]  reqValid = '0;
  logic [N*3-1:0] reqMode = '0;
  logic [N-1:0]  cpuPwrGood, ramPwrGood, saveDone, restoreDone;
  logic [N*3-1:0] coreMode;
  logic [N-1:0]  cpuClkEn, snoopClkEn, cpuPwrEn, ramPwrEn, cpuIso;
  logic [N-1:0]  coreRstN, saveReq, restoreReq, errFlag;
  logic [N-1:0]  freezeCpu = '0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.NUM_CORES(N), .TIMEOUT_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .timeoutLimit(timeoutLimit),
    .reqValid(reqValid), .reqMode(reqMode),
    .cpuPwrGood(cpuPwrGood), .ramPwrGood(ramPwrGood),
    .saveDone(saveDone), .restoreDone(restoreDone),
    .coreMode(coreMode), .cpuClkEn(cpuClkEn), .snoopClkEn(snoopClkEn),
    .cpuPwrEn(cpuPwrEn), .ramPwrEn(ramPwrEn), .cpuIso(cpuIso),
    .coreRstN(coreRstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .errFlag(errFlag)
  );

  // Power switch and memory handshake models
  logic [N-1:0] cp1, cp2, cpG, rp1, rp2, rpG, sv1, sv2, rs1, rs2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cp1 <= '1; cp2 <= '1; cpG <= '1;
      rp1 <= '1; rp2 <= '1; rpG <= '1;
      sv1 <= '0; sv2 <= '0; rs1 <= '0; rs2 <= '0;
    end else begin
      cp1 <= cpuPwrEn; cp2 <= cp1;
      cpG <= (freezeCpu & cpG) | (~freezeCpu & cp2);
      rp1 <= ramPwrEn; rp2 <= rp1; rpG <= rp2;
      sv1 <= saveReq; sv2 <= sv1;
      rs1 <= restoreReq; rs2 <= rs1;
    end
  end
  assign cpuPwrGood  = cpG;
  assign ramPwrGood  = rpG;
  assign saveDone    = saveReq & sv2;
  assign restoreDone = restoreReq & rs2;

  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard for core 0 mode changes
  int    expQ[$];
  string tagQ[$];
  int    lastMode = 0;

  task automatic expectMode(int m, string tag);
    expQ.push_back(m);
    tagQ.push_back(tag);
  endtask

  // Event stamps and rule counters, core 0 unless noted
  int cyc = 0;
  int tSaveFall = 0, tIsoRise = 0, tCpuOff = 0, tCpuOn = 0, tIsoFall = 0;
  int saveCnt = 0, restoreCnt = 0;
  int isoViol = 0, ramViol = 0, rstViol = 0;

  initial begin
    logic pSave, pIso, pPwr, pRest;
    pSave = 1'b0; pIso = 1'b0; pPwr = 1'b1; pRest = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        int m;
        m = int'(coreMode[2:0]);
        if (m != lastMode) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R8", "unexpected core0 mode", m, lastMode);
          end else begin
            int e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            chk(m == e, t, "core0 mode step", m, e);
          end
          lastMode = m;
        end
        if (pSave && !saveReq[0]) tSaveFall = cyc;
        if (!pSave && saveReq[0]) saveCnt++;
        if (!pIso && cpuIso[0]) tIsoRise = cyc;
        if (pIso && !cpuIso[0]) tIsoFall = cyc;
        if (pPwr && !cpuPwrEn[0]) tCpuOff = cyc;
        if (!pPwr && cpuPwrEn[0]) tCpuOn = cyc;
        if (!pRest && restoreReq[0]) restoreCnt++;
        pSave = saveReq[0]; pIso = cpuIso[0];
        pPwr = cpuPwrEn[0]; pRest = restoreReq[0];
        if ((~cpuPwrEn & ~cpuIso) != '0) isoViol++;
        if ((~ramPwrEn & cpuPwrEn) != '0) ramViol++;
        if ((~cpuPwrEn & (coreRstN | cpuClkEn | snoopClkEn)) != '0) rstViol++;
      end
    end
  end

  task automatic reqCore(int c, logic [2:0] m);
    @(negedge clk);
    reqValid = '0;
    reqValid[c] = 1'b1;
    reqMode[c*3 +: 3] = m;
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic waitIdle(string tag);
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(expQ.size() == 0, tag, "scoreboard drained", expQ.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic waitMode(int c, int m, string tag);
    int n;
    n = 0;
    while (int'(coreMode[c*3 +: 3]) != m && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(int'(coreMode[c*3 +: 3]) == m, tag, "reach mode", int'(coreMode[c*3 +: 3]), m);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    int s0, r0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(coreMode == '0, "R1", "all modes run", int'(coreMode), 0);
    chk(cpuClkEn == '1 && snoopClkEn == '1, "R1", "clocks on", int'(cpuClkEn), 255);
    chk(cpuPwrEn == '1 && ramPwrEn == '1, "R1", "power on", int'(cpuPwrEn), 255);
    chk(cpuIso == '0 && errFlag == '0, "R1", "iso and err low", int'(cpuIso | errFlag), 0);
    chk(coreRstN == '1, "R1", "reset released", int'(coreRstN), 255);

    // R2 light-sleep
    expectMode(1, "R2");
    reqCore(0, 3'd1);
    waitIdle("R2");
    chk(!cpuClkEn[0] && snoopClkEn[0], "R2", "exec clk off snoop on",
        int'({cpuClkEn[0], snoopClkEn[0]}), 1);
    chk(cpuPwrEn[0] && ramPwrEn[0], "R2", "domains powered", int'(cpuPwrEn[0]), 1);

    // R3 sleep
    expectMode(2, "R3");
    reqCore(0, 3'd2);
    waitIdle("R3");
    chk(!cpuClkEn[0] && !snoopClkEn[0], "R3", "both clocks off",
        int'({cpuClkEn[0], snoopClkEn[0]}), 0);
    chk(cpuPwrEn[0] && ramPwrEn[0], "R3", "domains powered", int'(ramPwrEn[0]), 1);

    // R4 resume-standby entry from sleep (passes through run)
    s0 = saveCnt;
    expectMode(0, "R4"); expectMode(5, "R4"); expectMode(3, "R4");
    reqCore(0, 3'd3);
    waitIdle("R4");
    chk(saveCnt == s0 + 1, "R4", "one save request", saveCnt, s0 + 1);
    chk(tSaveFall <= tIsoRise, "R4", "save done before isolation", tSaveFall, tIsoRise);
    chk(tIsoRise < tCpuOff, "R4", "isolation before power cut", tIsoRise, tCpuOff);
    chk(ramPwrEn[0] && !cpuPwrEn[0], "R4", "ram kept, logic off",
        int'({ramPwrEn[0], cpuPwrEn[0]}), 2);
    chk(!coreRstN[0], "R11", "reset held in standby", int'(coreRstN[0]), 0);
    chk(coreMode[8:6] == 3'd0 && cpuClkEn[2], "R10", "core2 untouched",
        int'(coreMode[8:6]), 0);

    // R5 resume from standby
    r0 = restoreCnt;
    expectMode(5, "R5"); expectMode(0, "R5");
    reqCore(0, 3'd0);
    waitIdle("R5");
    chk(restoreCnt == r0 + 1, "R5", "one restore request", restoreCnt, r0 + 1);
    chk(tCpuOn < tIsoFall, "R5", "power before iso release", tCpuOn, tIsoFall);
    chk(coreRstN[0] && cpuClkEn[0], "R11", "released after power-up",
        int'({coreRstN[0], cpuClkEn[0]}), 3);

    // R8 illegal code ignored
    reqCore(0, 3'd6);
    repeat (10) @(negedge clk);
    chk(coreMode[2:0] == 3'd0 && cpuClkEn[0], "R8", "code 6 ignored",
        int'(coreMode[2:0]), 0);

    // R8 requests held during a stretched transition, latest wins
    freezeCpu[0] = 1'b1;
    expectMode(5, "R8"); expectMode(3, "R8");
    expectMode(5, "R8"); expectMode(0, "R8"); expectMode(1, "R8");
    reqCore(0, 3'd3);
    waitMode(0, 5, "R8");
    reqCore(0, 3'd2);
    reqCore(0, 3'd1);
    chk(coreMode[2:0] == 3'd5, "R8", "still transitioning", int'(coreMode[2:0]), 5);
    freezeCpu[0] = 1'b0;
    waitIdle("R8");
    chk(!cpuClkEn[0] && snoopClkEn[0], "R8", "ended in light-sleep",
        int'({cpuClkEn[0], snoopClkEn[0]}), 1);

    // R6 power-off from light-sleep and cold restart
    expectMode(0, "R6"); expectMode(5, "R6"); expectMode(4, "R6");
    reqCore(0, 3'd4);
    waitIdle("R6");
    chk(!cpuPwrEn[0] && !ramPwrEn[0], "R6", "both domains off",
        int'({cpuPwrEn[0], ramPwrEn[0]}), 0);
    r0 = restoreCnt;
    s0 = saveCnt;
    expectMode(5, "R6"); expectMode(0, "R6");
    reqCore(0, 3'd0);
    waitIdle("R6");
    chk(restoreCnt == r0 && saveCnt == s0, "R6", "no save or restore on cold path",
        restoreCnt - r0, 0);
    chk(coreRstN[0] && ramPwrEn[0] && cpuPwrEn[0], "R6", "restarted",
        int'({coreRstN[0], ramPwrEn[0], cpuPwrEn[0]}), 7);

    // R6 standby directly to off, then back
    expectMode(5, "R6"); expectMode(3, "R6");
    reqCore(0, 3'd3);
    waitIdle("R6");
    expectMode(5, "R6"); expectMode(4, "R6");
    reqCore(0, 3'd4);
    waitIdle("R6");
    chk(!ramPwrEn[0], "R6", "ram off from standby", int'(ramPwrEn[0]), 0);
    expectMode(5, "R6"); expectMode(0, "R6");
    reqCore(0, 3'd0);
    waitIdle("R6");

    // R9 timeout on core 1
    chk(errFlag == '0, "R9", "no error on normal waits", int'(errFlag), 0);
    timeoutLimit = 16'd10;
    freezeCpu[1] = 1'b1;
    reqCore(1, 3'd4);
    repeat (30) @(negedge clk);
    chk(coreMode[5:3] == 3'd5, "R9", "core1 still waiting", int'(coreMode[5:3]), 5);
    chk(errFlag[1], "R9", "timeout flagged", int'(errFlag[1]), 1);
    chk(!errFlag[0] && coreMode[2:0] == 3'd0, "R10", "core0 unaffected",
        int'(errFlag[0]), 0);
    freezeCpu[1] = 1'b0;
    waitMode(1, 4, "R9");
    chk(errFlag[1], "R9", "flag sticky", int'(errFlag[1]), 1);

    // Continuous rule monitors
    chk(isoViol == 0, "R7", "isolation while unpowered", isoViol, 0);
    chk(ramViol == 0, "R6", "ram off while logic on", ramViol, 0);
    chk(rstViol == 0, "R11", "reset/clocks while unpowered", rstViol, 0);
    chk(expQ.size() == 0, "R8", "no leftover expected modes", expQ.size(), 0);

    finish();
  end

endmodule